// File: doc/BRIEF.md
# Reset Cause Capture Register

This block sits beside the reset controller of a small microcontroller and records why the last internal reset happened. Five on-chip detectors each report a problem as a one-cycle strobe:
- an illegal-opcode check, which fires when opcode FFh executes;
- a watchdog;
- a RAM parity checker;
- an illegal-memory-access detector;
- a low-voltage detector.

Any qualified strobe starts a fixed-length internal reset pulse. It also sets a sticky flag for its cause, and that flag survives the internal reset it triggered.

Software reads the flags as one byte. A whole-byte read clears them. A single-bit read is seen by the block but clears nothing. The external reset pin and the power-on reset are asynchronous and active-high. Both clear every flag at once. The block holds its reset output until two clock edges after they release.

RAM parity errors cause a reset only when the parity-reset enable is set, and only for data reads, not instruction fetches. The illegal-opcode check is suppressed while the debug-mode input is high.

Top module: `rst_cause_unit`

## Requirements
- R1: While `ext_rst_in` or `por_in` is high, `core_rst_o` is 1 and `rd_data` reads 00h.
- R2: Flag layout in `rd_data`: bit 7 illegal opcode, bit 4 watchdog, bit 2 RAM parity, bit 1 illegal memory access, bit 0 low voltage. Bits 6, 5 and 3 always read 0.
- R3: A clock edge with `exec_valid`=1, `exec_opcode`=FFh and `dbg_mode`=0 sets bit 7 and starts an internal reset. Any other opcode, or `dbg_mode`=1, has no effect.
- R4: `par_err` sets bit 2 and starts an internal reset only when `par_rst_en`=1 and `par_is_fetch`=0. Otherwise it has no effect.
- R5: A flag set by a request stays set through the internal reset it starts. A later request from another cause adds its flag and leaves the existing flags unchanged.
- R6: Requests arriving on the same edge all set their flags on that edge.
- R7: `rd_data` shows the flags after the edge on which they were set. A `rd_byte` strobe clears all flags on its edge.
- R8: A `rd_bit` strobe without `rd_byte` clears no flag.
- R9: When `rd_byte` and a request share an edge, the result is exactly the new request's flag.
- R10: `core_rst_o` goes high on the edge of a qualified request and stays high for exactly 16 cycles. A new request restarts the 16-cycle count.
- R11: An external or power-on reset clears the flags asynchronously. `core_rst_o` falls on the second clock edge after the reset input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_in | input | 1 | External reset pin, asynchronous, active-high |
| por_in | input | 1 | Power-on reset, asynchronous, active-high |
| exec_valid | input | 1 | Strobe: an opcode is being executed |
| exec_opcode | input | 8 | Opcode being executed |
| dbg_mode | input | 1 | Debug mode; suppresses the illegal-opcode check |
| wdt_req | input | 1 | Watchdog reset strobe |
| par_err | input | 1 | RAM parity error strobe |
| par_is_fetch | input | 1 | The parity error belongs to an instruction fetch |
| par_rst_en | input | 1 | Enables parity-error resets |
| iaw_req | input | 1 | Illegal memory access strobe |
| lvd_req | input | 1 | Low-voltage strobe |
| rd_byte | input | 1 | Whole-byte read strobe; clears the flags |
| rd_bit | input | 1 | Single-bit read strobe; clears nothing |
| rd_data | output | 8 | Flag register read data |
| core_rst_o | output | 1 | Combined reset to the core |

## Verification
Requests and reads are driven at the falling edge and take effect on the next rising edge. Flags and the reset output are checked at the falling edge that follows that rising edge. The 16-cycle pulse is measured by checking for high at sixteen consecutive falling edges and for low at the seventeenth. After an external or power-on reset drops, the reset output is checked high after the first rising edge and low after the second. The sweeps cover all 32 request combinations, all 8 parity qualifier cases and every opcode both with and without debug mode, waiting out each pulse before the next stimulus.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int NCAUSE  = 5;
    localparam int REG_W   = 8;
    // cause indices inside the internal vector
    localparam int C_BADOP = 0;
    localparam int C_WDT   = 1;
    localparam int C_PAR   = 2;
    localparam int C_IAW   = 3;
    localparam int C_LVD   = 4;
    // bit positions in the software-visible byte
    localparam int P_BADOP = 7;
    localparam int P_WDT   = 4;
    localparam int P_PAR   = 2;
    localparam int P_IAW   = 1;
    localparam int P_LVD   = 0;

    typedef logic [NCAUSE-1:0] cause_t;

    function automatic logic [REG_W-1:0] pack_flags(input cause_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[P_BADOP] = c[C_BADOP];
        r[P_WDT]   = c[C_WDT];
        r[P_PAR]   = c[C_PAR];
        r[P_IAW]   = c[C_IAW];
        r[P_LVD]   = c[C_LVD];
        return r;
    endfunction
endpackage

// File: rtl/rsf_rst_sync.sv
module rsf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic rst_s
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], 1'b0};
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) st_q <= '{sh: '1};
        else      st_q <= st_d;
    end

    assign rst_s = st_q.sh[STAGES-1];
endmodule

// File: rtl/rsf_cause_decode.sv
module rsf_cause_decode
    import rsf_pkg::*;
#(
    parameter int            OPC_W   = 8,
    parameter logic [OPC_W-1:0] BAD_OPC = '1
) (
    input  logic             exec_valid,
    input  logic [OPC_W-1:0] exec_opcode,
    input  logic             dbg_mode,
    input  logic             wdt_req,
    input  logic             par_err,
    input  logic             par_is_fetch,
    input  logic             par_rst_en,
    input  logic             iaw_req,
    input  logic             lvd_req,
    output cause_t           cause
);
    always_comb begin
        cause          = '0;
        cause[C_BADOP] = exec_valid && (exec_opcode == BAD_OPC) && !dbg_mode;
        cause[C_WDT]   = wdt_req;
        cause[C_PAR]   = par_err && par_rst_en && !par_is_fetch;
        cause[C_IAW]   = iaw_req;
        cause[C_LVD]   = lvd_req;
    end
endmodule

// File: rtl/rsf_stretch.sv
module rsf_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } str_t;

    str_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig)
            st_d.cnt = CW'(HOLD);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);

    assert_countdown_R10: assert property (@(posedge clk) disable iff (rst)
        (!trig && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    assert_load_R10: assert property (@(posedge clk) disable iff (rst)
        trig |=> (st_q.cnt == CW'(HOLD)));
endmodule

// File: rtl/rsf_flag_reg.sv
module rsf_flag_reg
    import rsf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t set,
    input  logic   rd_clr,
    output cause_t flags
);
    typedef struct packed {
        cause_t fl;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr) st_d.fl = '0;
        st_d.fl = st_d.fl | set;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flags = st_q.fl;

    assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> ((st_q.fl & $past(st_q.fl)) == $past(st_q.fl)));
    assert_clr_new_R9: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (st_q.fl == $past(set)));
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
    import rsf_pkg::*;
#(
    parameter int HOLD_CYC    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int OPC_W       = 8,
    parameter logic [OPC_W-1:0] BAD_OPC = 8'hFF
) (
    input  logic             clk,
    input  logic             ext_rst_in,
    input  logic             por_in,
    input  logic             exec_valid,
    input  logic [OPC_W-1:0] exec_opcode,
    input  logic             dbg_mode,
    input  logic             wdt_req,
    input  logic             par_err,
    input  logic             par_is_fetch,
    input  logic             par_rst_en,
    input  logic             iaw_req,
    input  logic             lvd_req,
    input  logic             rd_byte,
    input  logic             rd_bit,
    output logic [REG_W-1:0] rd_data,
    output logic             core_rst_o
);
    logic   arst, rst_s, pulse_on, any_req;
    cause_t cause, flags;

    assign arst = ext_rst_in | por_in;

    rsf_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .arst(arst), .rst_s(rst_s)
    );

    rsf_cause_decode #(.OPC_W(OPC_W), .BAD_OPC(BAD_OPC)) u_dec (
        .exec_valid(exec_valid), .exec_opcode(exec_opcode), .dbg_mode(dbg_mode),
        .wdt_req(wdt_req), .par_err(par_err), .par_is_fetch(par_is_fetch),
        .par_rst_en(par_rst_en), .iaw_req(iaw_req), .lvd_req(lvd_req),
        .cause(cause)
    );

    assign any_req = |cause;

    rsf_stretch #(.HOLD(HOLD_CYC)) u_str (
        .clk(clk), .rst(rst_s), .trig(any_req), .active(pulse_on)
    );

    // only a whole-byte read clears; rd_bit is intentionally unused for state
    rsf_flag_reg u_flags (
        .clk(clk), .rst(rst_s), .set(cause), .rd_clr(rd_byte), .flags(flags)
    );

    assign rd_data    = pack_flags(flags);
    assign core_rst_o = rst_s | pulse_on;

    assert_reserved_R2: assert property (@(posedge clk)
        (rd_data[6] == 1'b0) && (rd_data[5] == 1'b0) && (rd_data[3] == 1'b0));
    assert_req_rst_R10: assert property (@(posedge clk) disable iff (rst_s)
        any_req |=> core_rst_o);
    assert_readclr_R7: assert property (@(posedge clk) disable iff (rst_s)
        (rd_byte && !any_req) |=> (rd_data == '0));
    assert_bitread_R8: assert property (@(posedge clk) disable iff (rst_s)
        (rd_bit && !rd_byte) |=> ((rd_data & $past(rd_data)) == $past(rd_data)));
    assert_fetch_par_R4: assert property (@(posedge clk) disable iff (rst_s)
        (par_err && par_is_fetch && !rd_byte) |=> (rd_data[P_PAR] == $past(rd_data[P_PAR])));
    assert_dbg_opc_R3: assert property (@(posedge clk) disable iff (rst_s)
        (dbg_mode && !rd_byte) |=> (rd_data[P_BADOP] == $past(rd_data[P_BADOP])));
endmodule

// File: tb/tb_rst_cause_unit.sv
module tb_rst_cause_unit;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic ext_rst_in = 1'b1, por_in = 1'b0;
    logic exec_valid = 0, dbg_mode = 0, wdt_req = 0, par_err = 0, par_is_fetch = 0;
    logic par_rst_en = 0, iaw_req = 0, lvd_req = 0, rd_byte = 0, rd_bit = 0;
    logic [7:0] exec_opcode = 8'h00;
    logic [7:0] rd_data;
    logic core_rst_o;

    int checks = 0, fails = 0;
    bit done = 0;

    rst_cause_unit dut (
        .clk(clk), .ext_rst_in(ext_rst_in), .por_in(por_in),
        .exec_valid(exec_valid), .exec_opcode(exec_opcode), .dbg_mode(dbg_mode),
        .wdt_req(wdt_req), .par_err(par_err), .par_is_fetch(par_is_fetch),
        .par_rst_en(par_rst_en), .iaw_req(iaw_req), .lvd_req(lvd_req),
        .rd_byte(rd_byte), .rd_bit(rd_bit), .rd_data(rd_data), .core_rst_o(core_rst_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        exec_valid = 0; wdt_req = 0; par_err = 0; iaw_req = 0; lvd_req = 0;
        rd_byte = 0; rd_bit = 0;
    endtask

    // bits of m: 0 badop, 1 wdt, 2 parity, 3 iaw, 4 lvd
    function automatic logic [7:0] exp_of(input int m);
        return 8'((m & 1) * 128 + ((m >> 1) & 1) * 16 + ((m >> 2) & 1) * 4
                  + ((m >> 3) & 1) * 2 + ((m >> 4) & 1));
    endfunction

    task automatic pulse(input int m, input bit rdb);
        @(negedge clk);
        exec_valid = m[0]; exec_opcode = m[0] ? 8'hFF : 8'h00;
        wdt_req = m[1]; par_err = m[2]; par_rst_en = m[2]; par_is_fetch = 0;
        iaw_req = m[3]; lvd_req = m[4]; rd_byte = rdb;
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic wait_idle();
        repeat (17) @(negedge clk);
    endtask

    task automatic read_clear();
        @(negedge clk); rd_byte = 1;
        @(negedge clk); rd_byte = 0;
    endtask

    task automatic do_reset(input bit use_por, input string tag);
        @(negedge clk);
        if (use_por) por_in = 1; else ext_rst_in = 1;
        #1;
        chk({7'd0, core_rst_o}, 8'd1, {tag, " R1 rst high during"});
        chk(rd_data, 8'h00, {tag, " R11 flags cleared async"});
        repeat (3) @(negedge clk);
        chk(rd_data, 8'h00, {tag, " R1 flags zero during"});
        por_in = 0; ext_rst_in = 0;
        @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd1, {tag, " R11 held after 1st edge"});
        @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd0, {tag, " R11 released after 2nd edge"});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd1, "R1 reset output in reset");
        chk(rd_data, 8'h00, "R1 read data in reset");
        ext_rst_in = 0;
        @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd1, "R11 hold one edge");
        @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd0, "R11 release");

        // R6 / R2 sweep of all request combinations
        for (int m = 0; m < 32; m++) begin
            pulse(m, 0);
            chk(rd_data, exp_of(m), $sformatf("R6 R2 combo %0d flags", m));
            chk({7'd0, core_rst_o}, (m != 0) ? 8'd1 : 8'd0, $sformatf("R10 combo %0d rst", m));
            wait_idle();
            chk(rd_data, exp_of(m), $sformatf("R5 combo %0d survives", m));
            @(negedge clk); rd_byte = 1; #1;
            chk(rd_data, exp_of(m), $sformatf("R7 combo %0d visible during read", m));
            @(negedge clk); rd_byte = 0;
            chk(rd_data, 8'h00, $sformatf("R7 combo %0d cleared", m));
        end

        // R10 exact length and retrigger
        pulse(2, 0);
        for (int i = 0; i < 15; i++) begin
            chk({7'd0, core_rst_o}, 8'd1, $sformatf("R10 hold cycle %0d", i + 1));
            @(negedge clk);
        end
        chk({7'd0, core_rst_o}, 8'd1, "R10 hold cycle 16");
        @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd0, "R10 released after 16");
        pulse(2, 0);
        repeat (7) @(negedge clk);
        pulse(16, 0);
        for (int i = 0; i < 15; i++) @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd1, "R10 retrigger still high");
        @(negedge clk);
        chk({7'd0, core_rst_o}, 8'd0, "R10 retrigger released");
        chk(rd_data, 8'h11, "R5 two causes accumulated");

        // R8 bit read does not clear
        @(negedge clk); rd_bit = 1;
        @(negedge clk); rd_bit = 0;
        chk(rd_data, 8'h11, "R8 bit read keeps flags");
        // R9 read with a new request
        pulse(8, 1);
        chk(rd_data, 8'h02, "R9 read plus new request");
        wait_idle();
        read_clear();

        // R4 parity qualifier sweep
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            par_err = k[0]; par_rst_en = k[1]; par_is_fetch = k[2];
            @(negedge clk);
            par_err = 0; par_is_fetch = 0;
            chk(rd_data, (k == 3) ? 8'h04 : 8'h00, $sformatf("R4 parity case %0d", k));
            chk({7'd0, core_rst_o}, (k == 3) ? 8'd1 : 8'd0, $sformatf("R4 parity rst %0d", k));
            wait_idle();
            read_clear();
        end
        par_rst_en = 0;

        // R3 opcode sweep with and without debug
        for (int d = 0; d < 2; d++) begin
            for (int op = 0; op < 256; op++) begin
                @(negedge clk);
                dbg_mode = d[0]; exec_valid = 1; exec_opcode = 8'(op);
                @(negedge clk);
                exec_valid = 0;
                chk(rd_data, (op == 255 && d == 0) ? 8'h80 : 8'h00,
                    $sformatf("R3 opcode %02h dbg %0d", op, d));
                if (op == 255 && d == 0) begin
                    chk({7'd0, core_rst_o}, 8'd1, "R3 illegal opcode rst");
                    wait_idle();
                    read_clear();
                end
            end
        end
        dbg_mode = 0;

        // R11 resets clear flags
        pulse(31, 0);
        do_reset(0, "ext");
        pulse(31, 0);
        do_reset(1, "por");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule